// File: doc/BRIEF.md
# RMII to MII Gasket

This block sits between a MAC core that speaks in 4-bit nibbles and a reduced media interface that carries 2 bits per transfer. One 50 MHz reference clock times both directions, and a speed input picks 100 Mbps or 10 Mbps. At 10 Mbps every transfer slot lasts ten reference clocks.

On transmit, the block takes one nibble with its enable from the MAC. It then drives that nibble onto the line as two dibits, low dibit first. The MAC sees a request strobe that tells it when the next nibble is taken. This strobe stands in for a separate transmit clock.

On receive, the combined carrier/data-valid line can change at any time relative to the reference clock, so it passes through a synchronizer. The data and error lines are delayed by the same number of stages so that all three stay aligned. Nibble assembly locks onto the first non-zero dibit of a frame and hands each finished nibble to the MAC with a one-cycle strobe. Collisions have no dedicated pin, so the block infers a collision when its own transmit enable and the synchronized receive carrier are both high.

Top module: `rmii_gasket`

## Requirements
- R1: On a clock edge where `tx_nib_req` is high, the block captures `tx_nib` and `tx_en`. From the next cycle, `rmii_txd` carries `tx_nib[1:0]` for one dibit period, then `tx_nib[3:2]` for one dibit period. A dibit period is 1 clock at 100 Mbps and 10 clocks at 10 Mbps. `rmii_txen` equals the captured `tx_en` for both dibits.
- R2: Whenever `rmii_txen` is low, `rmii_txd` is 2'b00, whatever value `tx_nib` holds.
- R3: `tx_nib_req` is a one-cycle strobe. It repeats every 2 clocks at 100 Mbps (`speed_100`=1) and every 20 clocks at 10 Mbps (`speed_100`=0).
- R4: `rx_crs` follows `rmii_crs_dv` after exactly SYNC_STAGES (default 2) rising edges. `rmii_rxd` and `rmii_rx_er` are delayed by the same count before use.
- R5: Nibble assembly starts at the first non-zero received dibit after carrier asserts. Each nibble is {second dibit, first dibit}, so the first dibit lands in bits 1:0. A preamble of dibits 01 gives nibbles of value 5, and the dibit pair 01,11 gives 4'hD.
- R6: Each assembled nibble appears on `rx_nib` with a one-cycle `rx_nib_vld` strobe. During continuous reception the strobes are 2 clocks apart at 100 Mbps and 20 clocks apart at 10 Mbps. `rx_dv` is high from alignment until carrier is seen low at a sample slot.
- R7: While the synchronized carrier is low, received data is ignored: there is no `rx_nib_vld` strobe and `rx_dv` stays low.
- R8: `rx_er` is high, together with `rx_nib_vld`, for exactly the nibbles where the error input was sampled high during either dibit while carrier was high. It is low at all other times.
- R9: `col` is high one cycle after `rmii_txen` and the synchronized carrier are both high. It is low otherwise.
- R10: At 10 Mbps, received dibits are sampled once every 10 reference clocks. A dibit held for 10 clocks is therefore taken exactly once.
- R11: While reset is held, `rmii_txen`, `rmii_txd`, `rx_nib_vld`, `rx_dv`, `rx_er`, `rx_crs` and `col` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 50 MHz reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| speed_100 | input | 1 | 1 selects 100 Mbps, 0 selects 10 Mbps |
| tx_nib | input | 4 | Transmit nibble from the MAC |
| tx_en | input | 1 | Transmit enable from the MAC |
| tx_nib_req | output | 1 | Strobe: nibble and enable are captured at this edge |
| rmii_txd | output | 2 | Transmit dibit to the line |
| rmii_txen | output | 1 | Transmit enable to the line |
| rmii_crs_dv | input | 1 | Combined carrier/data-valid, asynchronous |
| rmii_rxd | input | 2 | Received dibit |
| rmii_rx_er | input | 1 | Receive error |
| rx_nib | output | 4 | Assembled receive nibble |
| rx_nib_vld | output | 1 | Strobe: `rx_nib` holds a new nibble |
| rx_dv | output | 1 | Frame data valid to the MAC |
| rx_er | output | 1 | Error flag for the strobed nibble |
| rx_crs | output | 1 | Synchronized carrier sense |
| col | output | 1 | Inferred collision |

## Verification
The assertions take for granted that `speed_100` is constant between resets. They also take for granted that the receive data and error lines are stable around the reference clock, with only the carrier line allowed to be asynchronous.

The bench keeps within these limits in three ways:
- It changes speed only while reset is held.
- It drives every input on the falling edge.
- At 10 Mbps it holds each received dibit for a full ten-clock window, so exactly one sample falls inside it whatever the phase of the divider.

// File: rtl/rmii_gasket.sv
module rmii_gasket #(
  parameter int SLOW_DIV    = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       speed_100,
  input  logic [3:0] tx_nib,
  input  logic       tx_en,
  output logic       tx_nib_req,
  output logic [1:0] rmii_txd,
  output logic       rmii_txen,
  input  logic       rmii_crs_dv,
  input  logic [1:0] rmii_rxd,
  input  logic       rmii_rx_er,
  output logic [3:0] rx_nib,
  output logic       rx_nib_vld,
  output logic       rx_dv,
  output logic       rx_er,
  output logic       rx_crs,
  output logic       col
);

  localparam int DW = (SLOW_DIV > 2) ? $clog2(SLOW_DIV) : 1;
  localparam logic [DW-1:0] DIV_LAST = DW'(SLOW_DIV - 1);

  logic [DW-1:0] div_cnt;
  logic          slot;

  always_ff @(posedge clk) begin
    if (!rst_n)                 div_cnt <= '0;
    else if (div_cnt == DIV_LAST) div_cnt <= '0;
    else                        div_cnt <= div_cnt + 1'b1;
  end

  assign slot = speed_100 | (div_cnt == DIV_LAST);

  // transmit: split each nibble into two dibits, low first
  logic       tx_ph;
  logic [1:0] tx_hi;

  assign tx_nib_req = slot & ~tx_ph;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_ph     <= 1'b0;
      tx_hi     <= 2'b00;
      rmii_txd  <= 2'b00;
      rmii_txen <= 1'b0;
    end else if (slot) begin
      tx_ph <= ~tx_ph;
      if (!tx_ph) begin
        rmii_txen <= tx_en;
        rmii_txd  <= tx_en ? tx_nib[1:0] : 2'b00;
        tx_hi     <= tx_en ? tx_nib[3:2] : 2'b00;
      end else begin
        rmii_txd  <= tx_hi;
      end
    end
  end

  // receive: synchronize carrier, delay data and error to match
  logic [SYNC_STAGES-1:0] crs_pipe;
  logic [SYNC_STAGES-1:0] er_pipe;
  logic [1:0]             rxd_pipe [SYNC_STAGES];
  logic                   crs_s, er_s;
  logic [1:0]             rxd_s;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      crs_pipe <= '0;
      er_pipe  <= '0;
      for (int i = 0; i < SYNC_STAGES; i++) rxd_pipe[i] <= 2'b00;
    end else begin
      crs_pipe <= {crs_pipe[SYNC_STAGES-2:0], rmii_crs_dv};
      er_pipe  <= {er_pipe[SYNC_STAGES-2:0], rmii_rx_er};
      rxd_pipe[0] <= rmii_rxd;
      for (int i = 1; i < SYNC_STAGES; i++) rxd_pipe[i] <= rxd_pipe[i-1];
    end
  end

  assign crs_s  = crs_pipe[SYNC_STAGES-1];
  assign er_s   = er_pipe[SYNC_STAGES-1];
  assign rxd_s  = rxd_pipe[SYNC_STAGES-1];
  assign rx_crs = crs_s;

  // nibble assembly, aligned on first non-zero dibit
  logic       aligned, rx_ph, er_acc;
  logic [1:0] rx_lo;

  assign rx_dv = aligned;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      aligned    <= 1'b0;
      rx_ph      <= 1'b0;
      er_acc     <= 1'b0;
      rx_lo      <= 2'b00;
      rx_nib     <= 4'h0;
      rx_nib_vld <= 1'b0;
      rx_er      <= 1'b0;
    end else begin
      rx_nib_vld <= 1'b0;
      rx_er      <= 1'b0;
      if (slot) begin
        if (!crs_s) begin
          aligned <= 1'b0;
          rx_ph   <= 1'b0;
          er_acc  <= 1'b0;
        end else if (!aligned) begin
          if (rxd_s != 2'b00) begin
            aligned <= 1'b1;
            rx_ph   <= 1'b1;
            rx_lo   <= rxd_s;
            er_acc  <= er_s;
          end
        end else if (!rx_ph) begin
          rx_ph  <= 1'b1;
          rx_lo  <= rxd_s;
          er_acc <= er_s;
        end else begin
          rx_ph      <= 1'b0;
          rx_nib     <= {rxd_s, rx_lo};
          rx_nib_vld <= 1'b1;
          rx_er      <= er_acc | er_s;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) col <= 1'b0;
    else        col <= rmii_txen & crs_s;
  end

  AST_TXD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !rmii_txen |-> rmii_txd == 2'b00);                               // R2
  AST_REQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    tx_nib_req |=> !tx_nib_req);                                     // R3
  AST_NIB_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rx_nib_vld |=> !rx_nib_vld);                                     // R6
  AST_NIB_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    rx_nib_vld |-> rx_dv);                                           // R7
  AST_ERR_WITH_NIB: assert property (@(posedge clk) disable iff (!rst_n)
    rx_er |-> rx_nib_vld);                                           // R8
  AST_COL_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(col) |-> $past(rmii_txen));                                // R9

endmodule

// File: tb/tb_rmii_gasket.sv
module tb_rmii_gasket;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       speed_100 = 1'b1;
  logic [3:0] tx_nib = 4'h0;
  logic       tx_en = 1'b0;
  logic       tx_nib_req;
  logic [1:0] rmii_txd;
  logic       rmii_txen;
  logic       rmii_crs_dv = 1'b0;
  logic [1:0] rmii_rxd = 2'b00;
  logic       rmii_rx_er = 1'b0;
  logic [3:0] rx_nib;
  logic       rx_nib_vld, rx_dv, rx_er, rx_crs, col;

  int total = 0;
  int bad = 0;

  always #2 clk = ~clk;

  rmii_gasket dut (
    .clk(clk), .rst_n(rst_n), .speed_100(speed_100),
    .tx_nib(tx_nib), .tx_en(tx_en), .tx_nib_req(tx_nib_req),
    .rmii_txd(rmii_txd), .rmii_txen(rmii_txen),
    .rmii_crs_dv(rmii_crs_dv), .rmii_rxd(rmii_rxd), .rmii_rx_er(rmii_rx_er),
    .rx_nib(rx_nib), .rx_nib_vld(rx_nib_vld), .rx_dv(rx_dv), .rx_er(rx_er),
    .rx_crs(rx_crs), .col(col)
  );

  task automatic chk(input string rq, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d t=%0t", rq, act, exp, $time);
    end
  endtask

  task automatic reset_dut(input bit spd);
    @(negedge clk);
    rst_n = 1'b0; speed_100 = spd;
    tx_en = 1'b0; tx_nib = 4'h0;
    rmii_crs_dv = 1'b0; rmii_rxd = 2'b00; rmii_rx_er = 1'b0;
    repeat (3) @(negedge clk);
    chk("R11 txen", rmii_txen, 0);
    chk("R11 txd", rmii_txd, 0);
    chk("R11 nib_vld", rx_nib_vld, 0);
    chk("R11 dv", rx_dv, 0);
    chk("R11 er", rx_er, 0);
    chk("R11 crs", rx_crs, 0);
    chk("R11 col", col, 0);
    rst_n = 1'b1;
  endtask

  task automatic run_tx(input bit spd);
    int per  = spd ? 2 : 20;
    int half = spd ? 1 : 10;
    @(negedge clk);
    while (!tx_nib_req) @(negedge clk);
    for (int k = 0; k < 20; k++) begin
      logic [3:0] nib = 4'(k * 7 + 3);
      logic       en  = (k < 16);
      tx_nib = nib; tx_en = en;
      for (int j = 0; j < per; j++) begin
        int exp_d;
        @(negedge clk);
        exp_d = !en ? 0 : (j < half ? int'(nib[1:0]) : int'(nib[3:2]));
        if (en) chk("R1 txd", rmii_txd, exp_d);
        else    chk("R2 txd quiet", rmii_txd, 0);
        chk("R1 txen", rmii_txen, int'(en));
        chk("R3 req", tx_nib_req, int'(j == per - 1));
        chk("R9 no col", col, 0);
      end
    end
    tx_en = 1'b0;
  endtask

  task automatic run_rx(input bit spd);
    int per = spd ? 1 : 10;
    logic [1:0] st [64];
    logic       ef [64];
    logic [3:0] en_exp [32];
    logic       er_exp [32];
    int nd = 0, ne = 0, got = 0, last = 0, tot;
    for (int i = 0; i < 3; i++) begin st[nd] = 2'b00; ef[nd] = 1'b0; nd++; end
    for (int i = 0; i < 7; i++) begin
      st[nd] = 2'b01; ef[nd] = 1'b0; nd++;
      st[nd] = 2'b01; ef[nd] = 1'b0; nd++;
      en_exp[ne] = 4'h5; er_exp[ne] = 1'b0; ne++;
    end
    st[nd] = 2'b01; ef[nd] = 1'b0; nd++;
    st[nd] = 2'b11; ef[nd] = 1'b0; nd++;
    en_exp[ne] = 4'hD; er_exp[ne] = 1'b0; ne++;
    for (int i = 0; i < 8; i++) begin
      logic [3:0] v = 4'(i * 11 + 6);
      st[nd] = v[1:0]; ef[nd] = (i == 2); nd++;
      st[nd] = v[3:2]; ef[nd] = 1'b0; nd++;
      en_exp[ne] = v; er_exp[ne] = (i == 2); ne++;
    end
    // R7: data and error with carrier low are ignored
    rmii_crs_dv = 1'b0; rmii_rxd = 2'b11; rmii_rx_er = 1'b1;
    for (int c = 0; c < 30; c++) begin
      @(negedge clk);
      chk("R7 no strobe", rx_nib_vld, 0);
      chk("R7 no dv", rx_dv, 0);
      chk("R8 no err", rx_er, 0);
    end
    rmii_rx_er = 1'b0; rmii_rxd = 2'b00;
    tot = nd * per + 60;
    for (int c = 0; c < tot; c++) begin
      if (c > 0) @(negedge clk);
      if (c == 1) chk("R4 crs not yet", rx_crs, 0);
      if (c == 2) chk("R4 crs synced", rx_crs, 1);
      if (rx_nib_vld) begin
        if (got < ne) begin
          chk("R5 nibble", rx_nib, en_exp[got]);
          chk("R8 err flag", rx_er, int'(er_exp[got]));
        end
        chk("R6 dv", rx_dv, 1);
        if (got > 0) chk("R6 R10 spacing", c - last, 2 * per);
        last = c; got++;
      end else begin
        chk("R8 err only with nib", rx_er, 0);
      end
      if (c < nd * per) begin
        rmii_crs_dv = 1'b1; rmii_rxd = st[c / per]; rmii_rx_er = ef[c / per];
      end else begin
        rmii_crs_dv = 1'b0; rmii_rxd = 2'b00; rmii_rx_er = 1'b0;
      end
    end
    chk("R5 nibble count", got, ne);
    chk("R6 dv falls", rx_dv, 0);
  endtask

  task automatic run_col();
    rmii_crs_dv = 1'b1;
    repeat (4) @(negedge clk);
    chk("R9 carrier alone", col, 0);
    while (!tx_nib_req) @(negedge clk);
    tx_nib = 4'hA; tx_en = 1'b1;
    @(negedge clk);
    chk("R9 col before", col, 0);
    @(negedge clk);
    chk("R9 col set", col, 1);
    tx_en = 1'b0;
    repeat (3) @(negedge clk);
    chk("R9 col clears", col, 0);
    rmii_crs_dv = 1'b0;
  endtask

  initial begin
    reset_dut(1'b1); run_tx(1'b1);
    reset_dut(1'b1); run_rx(1'b1);
    reset_dut(1'b0); run_tx(1'b0);
    reset_dut(1'b0); run_rx(1'b0);
    reset_dut(1'b1); run_col();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule